// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer with a small register file on the system bus. Its down-counter runs on a separate low-speed watchdog clock. Software controls it only by writing fixed 16-bit codes to a key register. One code opens the divider and reload registers for writing. Another code starts the timer, and after that software cannot stop it. A third code reloads the counter. If software does not write the reload code before the counter runs out, the block sends a one-cycle reset request to the system reset logic.

Every accepted write to the divider or reload register has to cross into the watchdog clock domain. A status bit for that register stays high until the new value has arrived. The watchdog side sends an acknowledge back to clear the bit. While the bit is set, further writes to that register are ignored. This keeps the value stable while the watchdog side samples it.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF, the status register reads 0, the timer is stopped and the registers are locked.
- R2: Word offsets: 0x0 is the key (reads as 0), 0x4 is the divider code in bits [2:0], 0x8 is the reload value in bits [11:0], 0xC is the status with bit 0 = divider update pending and bit 1 = reload update pending. A key write is recognised only when bits [31:16] are zero.
- R3: Key 0x5555 unlocks the divider and reload registers. Any other key write locks them again. Writes to a locked register leave its value unchanged.
- R4: An accepted divider or reload write sets its status bit on the next bus cycle. The bit clears within 24 bus cycles, once the value has reached the watchdog domain. A write to a register whose status bit is set is ignored.
- R5: Key 0xCCCC starts the timer and loads the counter. Before the start there is never a reset request.
- R6: While the timer runs, reset requests follow one another every (reload+1)*D watchdog clocks. D is 4<<code for codes 0 to 6, and 256 for code 7.
- R7: A reset request lasts exactly one watchdog clock cycle.
- R8: Key 0xAAAA reloads the counter and restarts the divider. Refreshing more often than the timeout prevents any request. A refresh that lands in the same cycle as the expiry wins, so no two requests are ever closer than the timeout.
- R9: Once started, no key write stops the timer. Writing 0xCCCC again does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wd_clk | input | 1 | Low-speed watchdog clock |
| wd_rst_n | input | 1 | Synchronous active-low reset, watchdog domain |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wd_reset_req | output | 1 | One watchdog-clock reset request on expiry |

## Verification
A refresh command and a counter expiry can land in the same watchdog clock cycle. The refresh must win, and no request may appear. The bench provokes this by sweeping the delay from one request to a refresh across the whole timeout, in small bus-clock steps. Because the two clocks are unrelated, some steps land on the expiry cycle itself. It judges the sweep by the smallest gap between requests, which must never fall below the programmed timeout, and by every request being one cycle wide.

// File: rtl/keyed_wdt_pkg.sv
// Shared constants for the keyed watchdog: key codes and register offsets.
// Assumes a 4-bit byte address with word-spaced registers.
package keyed_wdt_pkg;
    localparam int          ADDR_W      = 4;
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;
    localparam logic [ADDR_W-1:0] OFS_KEY = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DIV = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_RLD = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_STA = 4'hC;
    // Index of each event in the bus-to-watchdog crossing vector
    localparam int XF_DIV     = 0;
    localparam int XF_RLD     = 1;
    localparam int XF_REFRESH = 2;
    localparam int XF_START   = 3;
    localparam int XF_N       = 4;
endpackage

// File: rtl/keyed_wdt_xing.sv
// Single-event crossing between two unrelated clocks using a toggle.
// The source flips a toggle per event. The destination passes it through
// SYNC_N flops and emits a one-cycle pulse on each change it sees.
// Assumes source events are spaced further apart than the crossing latency.
module keyed_wdt_xing #(
    parameter int SYNC_N = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              tog;
    logic [SYNC_N-1:0] sync;
    logic              seen;

    // Flip the toggle once per source event
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    // Synchronise the toggle and remember the last settled value
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            sync <= '0;
            seen <= 1'b0;
        end else begin
            sync <= {sync[SYNC_N-2:0], tog};
            seen <= sync[SYNC_N-1];
        end
    end

    assign dst_pulse = sync[SYNC_N-1] ^ seen;
endmodule

// File: rtl/keyed_wdt_regs.sv
// Bus-domain register file: key decode, lock, divider and reload registers,
// update-pending status. Raises one-cycle command pulses for the crossings.
// Assumes ack_* pulses come back from the watchdog domain after each update.
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 3,
    parameter int RLD_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_div,
    input  logic              ack_rld,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] div_q,
    output logic [RLD_W-1:0]  rld_q,
    output logic              upd_div,
    output logic              upd_rld,
    output logic              cmd_refresh,
    output logic              cmd_start
);
    localparam logic [RLD_W-1:0] RLD_INIT = '1;

    logic       unlocked;
    logic [1:0] pend;
    logic       key_wr;

    assign key_wr      = sel && wr && (addr == OFS_KEY);
    assign upd_div     = sel && wr && (addr == OFS_DIV) && unlocked && !pend[0];
    assign upd_rld     = sel && wr && (addr == OFS_RLD) && unlocked && !pend[1];
    assign cmd_refresh = key_wr && (wdata == DATA_W'(KEY_REFRESH));
    assign cmd_start   = key_wr && (wdata == DATA_W'(KEY_START));

    // Lock state: only the unlock key opens, any other key closes
    always_ff @(posedge clk) begin
        if (!rst_n) unlocked <= 1'b0;
        else if (key_wr) unlocked <= (wdata == DATA_W'(KEY_UNLOCK));
    end

    // Divider and reload storage, written only when accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            rld_q <= RLD_INIT;
        end else begin
            if (upd_div) div_q <= wdata[CODE_W-1:0];
            if (upd_rld) rld_q <= wdata[RLD_W-1:0];
        end
    end

    // Pending flags: set by accepted write, cleared by returning acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 2'b00;
        else begin
            if (upd_div) pend[0] <= 1'b1;
            else if (ack_div) pend[0] <= 1'b0;
            if (upd_rld) pend[1] <= 1'b1;
            else if (ack_rld) pend[1] <= 1'b0;
        end
    end

    // Read multiplexer; the key register reads as zero
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DIV: rdata[CODE_W-1:0] = div_q;
            OFS_RLD: rdata[RLD_W-1:0]  = rld_q;
            OFS_STA: rdata[1:0]        = pend;
            default: rdata = '0;
        endcase
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(div_q) && $stable(rld_q))); // R3
    AST_PEND_FREEZES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |=> $stable(div_q)); // R4
    AST_PEND_FREEZES_RLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend[1] |=> $stable(rld_q)); // R4
endmodule

// File: rtl/keyed_wdt_prescaler.sv
// Watchdog-clock divider. It ticks once every D clocks, where D = 4<<code,
// capped at 2**DIV_W. A clear restarts the divider period.
// Assumes the code may change at any time; the count then folds at once.
module keyed_wdt_prescaler #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              clear,
    output logic              tick
);
    localparam int MAX_SH = DIV_W - 2;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_m1;
    int               sh;

    // Terminal count for the selected code
    always_comb begin
        sh     = (int'(code) > MAX_SH) ? MAX_SH : int'(code);
        div_m1 = DIV_W'((64'd1 << (sh + 2)) - 64'd1);
    end

    assign tick = (cnt >= div_m1);

    // Divider count, restarted on clear or terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (clear || tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0)); // R6
endmodule

// File: rtl/keyed_wdt_core.sv
// Watchdog-domain timer. It holds the synchronised divider and reload values,
// the sticky run flag and the down-counter, and raises the reset request.
// Assumes the upd_* pulses arrive only while the bus-side values are stable.
module keyed_wdt_core #(
    parameter int CODE_W = 3,
    parameter int RLD_W  = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_div,
    input  logic              upd_rld,
    input  logic [CODE_W-1:0] div_in,
    input  logic [RLD_W-1:0]  rld_in,
    input  logic              refresh,
    input  logic              start,
    output logic              reset_req
);
    localparam logic [RLD_W-1:0] RLD_INIT = '1;

    logic [CODE_W-1:0] div_w;
    logic [RLD_W-1:0]  rld_w;
    logic [RLD_W-1:0]  cnt;
    logic              running;
    logic              tick;
    logic              load;

    assign load = refresh || (start && !running);

    keyed_wdt_prescaler #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (div_w),
        .clear (load),
        .tick  (tick)
    );

    // Capture crossed configuration values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_w <= '0;
            rld_w <= RLD_INIT;
        end else begin
            if (upd_div) div_w <= div_in;
            if (upd_rld) rld_w <= rld_in;
        end
    end

    // Sticky run flag: set by start, never cleared except by reset
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else if (start) running <= 1'b1;
    end

    // Down-counter with expiry; a refresh takes priority over expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= RLD_INIT;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (load) begin
                cnt <= rld_w;
            end else if (running && tick) begin
                if (cnt == '0) begin
                    reset_req <= 1'b1;
                    cnt       <= rld_w;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R7
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> running); // R5
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R9
    AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !reset_req); // R8
    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (cnt == $past(rld_w))); // R6
endmodule

// File: rtl/keyed_wdt.sv
// Top of the keyed watchdog. It joins the bus register file, the clock-domain
// crossings for commands and acknowledges, and the watchdog-domain timer.
// Assumes bus_clk and wd_clk are unrelated, each with its own synchronous reset.
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 3,
    parameter int RLD_W  = 12,
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_req
);
    logic [XF_N-1:0]   fwd_src;
    logic [XF_N-1:0]   fwd_dst;
    logic [1:0]        ack_dst;
    logic [CODE_W-1:0] div_q;
    logic [RLD_W-1:0]  rld_q;

    keyed_wdt_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .RLD_W(RLD_W)) u_regs (
        .clk         (bus_clk),
        .rst_n       (bus_rst_n),
        .sel         (bus_sel),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .ack_div     (ack_dst[0]),
        .ack_rld     (ack_dst[1]),
        .rdata       (bus_rdata),
        .div_q       (div_q),
        .rld_q       (rld_q),
        .upd_div     (fwd_src[XF_DIV]),
        .upd_rld     (fwd_src[XF_RLD]),
        .cmd_refresh (fwd_src[XF_REFRESH]),
        .cmd_start   (fwd_src[XF_START])
    );

    // Bus to watchdog: configuration updates and key commands
    for (genvar i = 0; i < XF_N; i++) begin : g_fwd
        keyed_wdt_xing #(.SYNC_N(SYNC_N)) u_x (
            .src_clk   (bus_clk),
            .src_rst_n (bus_rst_n),
            .src_pulse (fwd_src[i]),
            .dst_clk   (wd_clk),
            .dst_rst_n (wd_rst_n),
            .dst_pulse (fwd_dst[i])
        );
    end

    // Watchdog to bus: acknowledges for the two configuration registers
    for (genvar j = 0; j < 2; j++) begin : g_ack
        keyed_wdt_xing #(.SYNC_N(SYNC_N)) u_x (
            .src_clk   (wd_clk),
            .src_rst_n (wd_rst_n),
            .src_pulse (fwd_dst[j]),
            .dst_clk   (bus_clk),
            .dst_rst_n (bus_rst_n),
            .dst_pulse (ack_dst[j])
        );
    end

    keyed_wdt_core #(.CODE_W(CODE_W), .RLD_W(RLD_W), .DIV_W(DIV_W)) u_core (
        .clk       (wd_clk),
        .rst_n     (wd_rst_n),
        .upd_div   (fwd_dst[XF_DIV]),
        .upd_rld   (fwd_dst[XF_RLD]),
        .div_in    (div_q),
        .rld_in    (rld_q),
        .refresh   (fwd_dst[XF_REFRESH]),
        .start     (fwd_dst[XF_START]),
        .reset_req (wd_reset_req)
    );
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
    logic        bus_clk = 0, wd_clk = 0;
    logic        bus_rst_n = 0, wd_rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        wd_reset_req;

    int checks = 0, fails = 0, done = 0;
    int wcyc = 0, pulse_count = 0, last_cyc = -1, last_gap = 0;
    int min_gap = 1000000, width_err = 0;
    logic prev_hi = 0;

    keyed_wdt uut (.*);

    always #10 bus_clk = ~bus_clk;
    always #18 wd_clk  = ~wd_clk;

    always @(posedge wd_clk) wcyc++;

    // Record request pulses, their widths and the gaps between them
    always @(negedge wd_clk) begin
        if (wd_reset_req) begin
            if (prev_hi) width_err++;
            else begin
                if (last_cyc >= 0) begin
                    last_gap = wcyc - last_cyc;
                    if (last_gap < min_gap) min_gap = last_gap;
                end
                last_cyc = wcyc;
                pulse_count++;
            end
        end
        prev_hi = wd_reset_req;
    end

    function automatic int exp_period(int code, int r);
        return (r + 1) * ((code >= 6) ? 256 : (4 << code));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output int d);
        @(negedge bus_clk);
        bus_addr = a;
        #2 d = int'(bus_rdata);
    endtask

    task automatic wait_clear(string req);
        int s, n;
        n = 0;
        rd(4'hC, s);
        while (s != 0 && n < 60) begin rd(4'hC, s); n++; end
        check(req, (n <= 24) ? 1 : 0, 1);
    endtask

    task automatic wait_pulses(int n);
        int s;
        s = pulse_count;
        while (pulse_count < s + n) @(posedge bus_clk);
    endtask

    task automatic configure(int code, int r);
        wr(4'h0, 32'h5555);
        wr(4'h4, code);
        wait_clear("R4");
        wr(4'h8, r);
        wait_clear("R4");
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, p0, code, r;
        void'($urandom(32'd2024));
        repeat (6) @(posedge bus_clk);
        bus_rst_n = 1;
        @(posedge wd_clk); wd_rst_n = 1;

        // R1 / R2 reset values
        rd(4'h4, v); check("R1 divider", v, 0);
        rd(4'h8, v); check("R1 reload", v, 32'hFFF);
        rd(4'hC, v); check("R1 status", v, 0);
        rd(4'h0, v); check("R2 key reads zero", v, 0);
        check("R1 request", int'(wd_reset_req), 0);

        // R3 locked writes ignored
        wr(4'h4, 5); wr(4'h8, 32'h123);
        rd(4'h4, v); check("R3 locked divider", v, 0);
        rd(4'h8, v); check("R3 locked reload", v, 32'hFFF);
        rd(4'hC, v); check("R3 no status", v, 0);
        // R2 key with nonzero upper half is not an unlock
        wr(4'h0, 32'h0001_5555); wr(4'h4, 3);
        rd(4'h4, v); check("R2 upper half", v, 0);

        // R4 status set and write-while-pending ignored
        wr(4'h0, 32'h5555);
        wr(4'h4, 2);
        rd(4'hC, v); check("R4 status set", v & 1, 1);
        wr(4'h4, 4);
        wait_clear("R4 clears");
        rd(4'h4, v); check("R4 pending write ignored", v, 2);
        wr(4'h8, 5);
        rd(4'hC, v); check("R4 reload status", v & 2, 2);
        wait_clear("R4 reload clears");
        rd(4'h8, v); check("R3 unlocked reload", v, 5);

        // R3 relock with another key
        wr(4'h0, 32'h1234); wr(4'h4, 7);
        rd(4'h4, v); check("R3 relock", v, 2);

        // R5 no request before start
        repeat (2000) @(posedge bus_clk);
        check("R5 idle", pulse_count, 0);

        // R5 / R6 start and period
        wr(4'h0, 32'hCCCC);
        wait_pulses(2);
        check("R5 started", (pulse_count >= 2) ? 1 : 0, 1);
        check("R6 directed period", last_gap, exp_period(2, 5));

        // R9 other keys do not stop it, second start does not reload
        wr(4'h0, 32'h0); wr(4'h0, 32'hCCCC); wr(4'h0, 32'h5555); wr(4'h0, 32'h0);
        wait_pulses(2);
        check("R9 still running", last_gap, exp_period(2, 5));

        // R6 random codes, with codes 7 and 6 forced first
        for (int i = 0; i < 7; i++) begin
            code = (i == 0) ? 7 : (i == 1) ? 6 : int'($urandom % 8);
            r = (code >= 5) ? int'($urandom % 4) : int'($urandom % 24);
            configure(code, r);
            wait_pulses(2);
            check($sformatf("R6 code=%0d reload=%0d", code, r), last_gap, exp_period(code, r));
        end

        // R8 keep-alive refreshing
        configure(0, 15);
        wait_pulses(2);
        wr(4'h0, 32'hAAAA);
        repeat (10) @(posedge bus_clk);
        p0 = pulse_count;
        for (int k = 0; k < 40; k++) begin
            repeat (38) @(posedge bus_clk);
            wr(4'h0, 32'hAAAA);
        end
        check("R8 refresh holds off", pulse_count, p0);

        // R8 refresh swept across the expiry cycle
        wait_pulses(1);
        min_gap = 1000000;
        for (int k = 0; k < 30; k++) begin
            wait_pulses(1);
            repeat (k * 4) @(negedge bus_clk);
            wr(4'h0, 32'hAAAA);
        end
        wait_pulses(1);
        check("R8 min gap", (min_gap >= exp_period(0, 15)) ? 1 : 0, 1);

        // R7 one-cycle requests
        check("R7 width", width_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule